// File: doc/BRIEF.md
# IF Sample Quantizer and Pin Formatter

This block takes a signed digital intermediate-frequency sample and turns it into the coarse sign/magnitude code that a baseband correlator expects on three narrow output pins. A small signed offset is first applied to the sample so that a known DC error can be cancelled. The result is clamped to the sample range and then sliced against a programmable threshold into either one or two magnitude bits plus a sign bit.

A mode bit chooses between two pin layouts. In the one-magnitude-bit layout, the sign sits on the top pin and the bottom pin is unused. In the two-magnitude-bit layout, the sign moves to the bottom pin and the magnitude occupies the upper two. A two-bit test select either leaves the normal sample path on the pins or replaces it with one of three groups of internal debug signals.

The pins are registered on the sample clock, and that clock is forwarded alongside them so that the receiver can capture the data.

Top module: `if_sample_slicer`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `ifPins` becomes 3'b000 after that edge.
- R2: The offset field is sign-magnitude with reversed significance. `offsetField[3]` has weight 1, `offsetField[2]` has weight 2 and `offsetField[1]` has weight 4. `offsetField[0]` = 1 subtracts the weighted sum times `OFFSET_STEP` (default 4) from the sample, and `offsetField[0]` = 0 adds it.
- R3: The corrected sample saturates at the signed limits of `SAMPLE_W` bits (default -128 and +127) instead of wrapping.
- R4: The sign bit is 1 when the corrected sample is zero or positive, and 0 when it is negative.
- R5: With `modeOneBit` = 0, the magnitude code from the absolute corrected value v is: 0 if v < T, 1 if T <= v < 2T, 2 if 2T <= v < 3T, and 3 if v >= 3T, where T = `magThresh`.
- R6: With `modeOneBit` = 1, the layout is `ifPins[2]` = sign, `ifPins[1]` = (v >= T), and `ifPins[0]` = 0.
- R7: With `modeOneBit` = 0, the layout is `ifPins[2]` = magnitude MSB, `ifPins[1]` = magnitude LSB, and `ifPins[0]` = sign.
- R8: `testSel` = 2'b01 selects the sample path. For the other values, `ifPins` loads a debug group on every clock edge, whatever `sampleValid` is: `dbgBus[2:0]` for 2'b00, `dbgBus[5:3]` for 2'b10 and `dbgBus[8:6]` for 2'b11.
- R9: On the sample path, `ifPins` keeps its value on every edge where `sampleValid` is low.
- R10: A sample presented with `sampleValid` high appears on `ifPins` just after the next rising edge, and not before it.
- R11: `sampleClkOut` follows the sample clock `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleIn | input | SAMPLE_W | Signed IF sample |
| sampleValid | input | 1 | Sample strobe |
| offsetField | input | 4 | Sign-magnitude offset correction |
| modeOneBit | input | 1 | 1: one magnitude bit, 0: two magnitude bits |
| testSel | input | 2 | Pin source select; 2'b01 selects the sample path |
| magThresh | input | SAMPLE_W | Magnitude threshold T |
| dbgBus | input | 9 | Three 3-bit debug groups |
| ifPins | output | 3 | Registered sample or debug pins |
| sampleClkOut | output | 1 | Forwarded sample clock |

## Verification
The hardest case to reach from the ports is saturation. A full-scale sample pushed further by the largest offset must land at a clamp point, and at the negative end the absolute value (128) needs one more bit than the sample has. The stimulus therefore pairs +127 with the largest positive correction and -128 with the largest negative one. It then checks that the result is still a full-scale magnitude with the correct sign, rather than a wrapped small value. The reversed bit weights of the offset are reached by setting its bits one at a time, at values that move the sample across a threshold only when the correct weight is used.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  localparam logic [1:0] TSEL_SAMPLE = 2'b01;

  typedef struct packed {
    logic       loadSample;
    logic       loadDebug;
    logic       oneBit;
    logic [1:0] dbgGroup;
  } slicer_ctl_t;
endpackage

// File: rtl/slicer_ctrl.sv
module slicer_ctrl
  import slicer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        modeOneBit,
  input  logic [1:0]  testSel,
  output slicer_ctl_t ctl
);
  always_comb begin
    ctl.oneBit     = modeOneBit;
    ctl.loadSample = (testSel == TSEL_SAMPLE) && sampleValid;
    ctl.loadDebug  = (testSel != TSEL_SAMPLE);
    unique case (testSel)
      2'b00:   ctl.dbgGroup = 2'd0;
      2'b10:   ctl.dbgGroup = 2'd1;
      2'b11:   ctl.dbgGroup = 2'd2;
      default: ctl.dbgGroup = 2'd0;
    endcase
  end

  // R8: the sample path and the debug path never load together
  a_r8_single_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadSample, ctl.loadDebug}));
endmodule

// File: rtl/slicer_datapath.sv
module slicer_datapath
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int OFFSET_STEP = 4,
  parameter int DBG_GROUPS  = 3,
  parameter int PIN_W       = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  slicer_ctl_t                ctl,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [3:0]                 offsetField,
  input  logic [SAMPLE_W-1:0]        magThresh,
  input  logic [DBG_GROUPS*PIN_W-1:0] dbgBus,
  output logic [PIN_W-1:0]           pinsQ
);
  localparam int CORR_W = 3 + $clog2(OFFSET_STEP + 1);
  localparam int EXT_W  = SAMPLE_W + CORR_W + 1;
  localparam int MAG_W  = SAMPLE_W + 2;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MIN_V = -EXT_W'(2 ** (SAMPLE_W - 1));

  logic [2:0]                     offMag;
  logic signed [EXT_W-1:0]        corrAmt, sumExt, corrected;
  logic [EXT_W-1:0]               absExt;
  logic [MAG_W-1:0]               absVal, th1, th2, th3;
  logic                           signBit, mag1;
  logic [1:0]                     mag2;
  logic [PIN_W-1:0]               dbgPick, samplePins;

  always_comb begin
    // reversed significance: field bit 3 is the weight-1 bit
    offMag  = {offsetField[1], offsetField[2], offsetField[3]};
    corrAmt = EXT_W'(offMag) * EXT_W'(OFFSET_STEP);
    sumExt  = offsetField[0] ? (EXT_W'(sampleIn) - corrAmt)
                             : (EXT_W'(sampleIn) + corrAmt);
    if (sumExt > MAX_V)      corrected = MAX_V;
    else if (sumExt < MIN_V) corrected = MIN_V;
    else                     corrected = sumExt;
  end

  always_comb begin
    signBit = (corrected >= 0);
    absExt  = signBit ? corrected : -corrected;
    absVal  = absExt[MAG_W-1:0];
    th1     = MAG_W'(magThresh);
    th2     = th1 << 1;
    th3     = th2 + th1;
    mag1    = (absVal >= th1);
    if (absVal >= th3)      mag2 = 2'd3;
    else if (absVal >= th2) mag2 = 2'd2;
    else if (absVal >= th1) mag2 = 2'd1;
    else                    mag2 = 2'd0;
    samplePins = ctl.oneBit ? {signBit, mag1, 1'b0} : {mag2, signBit};
  end

  always_comb begin
    dbgPick = '0;
    for (int g = 0; g < DBG_GROUPS; g++) begin
      if (int'(ctl.dbgGroup) == g) dbgPick = dbgBus[g*PIN_W +: PIN_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pinsQ <= '0;
    else if (ctl.loadDebug)  pinsQ <= dbgPick;
    else if (ctl.loadSample) pinsQ <= samplePins;
  end

  // R1: reset clears the pins on the following edge
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (pinsQ == '0));
  // R9: no load, no change
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadSample && !ctl.loadDebug) |=> $stable(pinsQ));
  // R6: spare pin low in one-bit layout
  a_r6_spare_pin_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadSample && ctl.oneBit) |=> (pinsQ[0] == 1'b0));
  // R4: negative corrected sample gives sign 0 in two-bit layout
  a_r4_sign_negative: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadSample && !ctl.oneBit && (corrected < 0)) |=> (pinsQ[0] == 1'b0));
  // R3: the clamped value stays inside the sample range
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (sumExt > MAX_V) |-> (corrected == MAX_V));
endmodule

// File: rtl/if_sample_slicer.sv
module if_sample_slicer
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int OFFSET_STEP = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic [3:0]                 offsetField,
  input  logic                       modeOneBit,
  input  logic [1:0]                 testSel,
  input  logic [SAMPLE_W-1:0]        magThresh,
  input  logic [8:0]                 dbgBus,
  output logic [2:0]                 ifPins,
  output logic                       sampleClkOut
);
  slicer_ctl_t ctl;

  slicer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .modeOneBit(modeOneBit), .testSel(testSel), .ctl(ctl)
  );

  slicer_datapath #(
    .SAMPLE_W(SAMPLE_W), .OFFSET_STEP(OFFSET_STEP), .DBG_GROUPS(3), .PIN_W(3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .offsetField(offsetField), .magThresh(magThresh), .dbgBus(dbgBus),
    .pinsQ(ifPins)
  );

  // R11: forwarded sample clock
  assign sampleClkOut = clk;
endmodule

// File: tb/if_sample_slicer_test.sv
module if_sample_slicer_test;
  logic              clk = 1'b0;
  logic              rstN;
  logic signed [7:0] sampleIn;
  logic              sampleValid;
  logic [3:0]        offsetField;
  logic              modeOneBit;
  logic [1:0]        testSel;
  logic [7:0]        magThresh;
  logic [8:0]        dbgBus;
  logic [2:0]        ifPins;
  logic              sampleClkOut;

  int applied = 0;
  int errors  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  if_sample_slicer uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .offsetField(offsetField), .modeOneBit(modeOneBit), .testSel(testSel),
    .magThresh(magThresh), .dbgBus(dbgBus), .ifPins(ifPins),
    .sampleClkOut(sampleClkOut)
  );

  // row: {sample, offset, mode, thresh, expected pins} ; step 4
  localparam int NV = 19;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {8'sd0,    4'b0000, 1'b0, 8'd16, 3'b001}, // R4 R7 zero is non-negative
    {8'sd20,   4'b0000, 1'b0, 8'd16, 3'b011}, // R5 code 1
    {8'sd40,   4'b0000, 1'b0, 8'd16, 3'b101}, // R5 code 2
    {-8'sd50,  4'b0000, 1'b0, 8'd16, 3'b110}, // R5 code 3, R4 negative
    {-8'sd1,   4'b0000, 1'b0, 8'd16, 3'b000}, // R4
    {8'sd12,   4'b1000, 1'b0, 8'd16, 3'b011}, // R2 bit3 weight 1 add
    {8'sd12,   4'b1001, 1'b0, 8'd16, 3'b001}, // R2 subtract
    {8'sd0,    4'b0010, 1'b0, 8'd16, 3'b011}, // R2 bit1 weight 4
    {8'sd0,    4'b0101, 1'b0, 8'd16, 3'b000}, // R2 bit2 weight 2 subtract
    {8'sd127,  4'b1110, 1'b0, 8'd16, 3'b111}, // R3 positive clamp
    {-8'sd128, 4'b1111, 1'b0, 8'd16, 3'b110}, // R3 negative clamp
    {8'sd20,   4'b0000, 1'b1, 8'd16, 3'b110}, // R6
    {8'sd15,   4'b0000, 1'b1, 8'd16, 3'b100}, // R6 below T
    {-8'sd16,  4'b0000, 1'b1, 8'd16, 3'b010}, // R6 negative at T
    {-8'sd3,   4'b0100, 1'b1, 8'd16, 3'b100}, // R6 R2 +8
    {8'sd14,   4'b0000, 1'b0, 8'd5,  3'b101}, // R5 small T
    {8'sd15,   4'b0000, 1'b0, 8'd5,  3'b111}, // R5 exactly 3T
    {8'sd47,   4'b0000, 1'b0, 8'd16, 3'b101}, // R5 just below 3T
    {8'sd48,   4'b0000, 1'b0, 8'd16, 3'b111}  // R5 at 3T
  };

  task automatic check(input logic [2:0] exp, input string req);
    applied++;
    if (ifPins !== exp) begin
      errors++;
      $display("FAIL %s: ifPins=%b expected=%b", req, ifPins, exp);
    end
  endtask

  task automatic drive(input logic [7:0] s, input logic [3:0] o, input logic m,
                       input logic [7:0] t, input logic v);
    @(negedge clk);
    sampleIn = s; offsetField = o; modeOneBit = m; magThresh = t; sampleValid = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sampleIn = '0; sampleValid = 1'b0; offsetField = '0;
    modeOneBit = 1'b0; testSel = 2'b01; magThresh = 8'd16; dbgBus = 9'b110_101_011;
    repeat (3) @(posedge clk);
    #1 check(3'b000, "R1 reset");
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][23:16], VEC[i][15:12], VEC[i][11], VEC[i][10:3], 1'b1);
      check(VEC[i][2:0], "R2-R7 vector");
    end

    // R9: hold while valid is low
    drive(8'sd40, 4'b0000, 1'b0, 8'd16, 1'b1);
    check(3'b101, "R9 setup");
    drive(-8'sd1, 4'b0000, 1'b0, 8'd16, 1'b0);
    check(3'b101, "R9 hold");
    drive(8'sd127, 4'b0000, 1'b1, 8'd16, 1'b0);
    check(3'b101, "R9 hold other mode");

    // R10: change visible only after the edge
    @(negedge clk);
    sampleIn = -8'sd50; modeOneBit = 1'b0; sampleValid = 1'b1;
    #1 check(3'b101, "R10 before edge");
    @(posedge clk); #1 check(3'b110, "R10 after edge");

    // R11: forwarded clock
    @(negedge clk); #0.5;
    applied++;
    if (sampleClkOut !== 1'b0) begin errors++; $display("FAIL R11: got %b expected 0", sampleClkOut); end
    @(posedge clk); #0.5;
    applied++;
    if (sampleClkOut !== 1'b1) begin errors++; $display("FAIL R11: got %b expected 1", sampleClkOut); end

    // R8: debug groups, loaded even with valid low
    @(negedge clk); sampleValid = 1'b0; testSel = 2'b00;
    @(posedge clk); #1 check(3'b011, "R8 group 00");
    @(negedge clk); testSel = 2'b10;
    @(posedge clk); #1 check(3'b101, "R8 group 10");
    @(negedge clk); testSel = 2'b11;
    @(posedge clk); #1 check(3'b110, "R8 group 11");
    @(negedge clk); dbgBus = 9'b001_000_000;
    @(posedge clk); #1 check(3'b001, "R8 follows bus");
    @(negedge clk); testSel = 2'b01; sampleIn = 8'sd20; modeOneBit = 1'b1; sampleValid = 1'b1;
    @(posedge clk); #1 check(3'b110, "R8 back to sample path");

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1 check(3'b000, "R1 reset mid-run");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule